// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Router

This block sits beside a GPIO bank and gives each of up to four processors a private view of the bank's interrupts. Each processor owns three registers in a small address window: a latched edge-cause register, an edge enable mask and a level enable mask. The bank feeds the router a polarity-adjusted input vector (used directly as the level source) and a one-cycle pulse vector that marks detected edges. A pulse sets the matching bit in every processor's cause register, and each processor then acknowledges its own copy without disturbing the others.

For each processor the pending set is the masked level vector ORed with the masked edge causes. The pending lines are folded in groups of eight, so each processor drives its own set of grouped interrupt outputs. All outputs are registered. A processor's outputs depend only on its own registers and the shared inputs. The bank's global cause and mask registers are separate from this window and keep working alongside it.

Top module: `gpio_pcpu_irq_router`

## Requirements
- R1: Out of reset every cause, edge mask and level mask register reads 0 and every interrupt output is 0.
- R2: Byte address map, with the processor number n (0 to 3) on address bits [3:2]. The edge cause is at n*4, the edge mask is at 0x10 + n*4 and the level mask is at 0x20 + n*4. A read strobe returns the addressed register on `reg_rdata` in the following cycle. A mask write stores all 32 bits.
- R3: A pulse on bit i of `edge_pulse` sets bit i of the cause register of every processor. The new value is visible from the next cycle.
- R4: A write to a processor's cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. A cause bit rises only through an edge pulse.
- R5: When an edge pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Output `irq[n*4+g]` is the OR, over lines 8g to 8g+7, of (level input AND level mask of n) OR (cause of n AND edge mask of n). It follows a change of its inputs or registers one cycle later.
- R7: A write to one processor's registers changes no other processor's registers or outputs.
- R8: Offsets 0x30 to 0x3C are unmapped. Reads there return 0 and writes there change nothing.
- R9: The level path holds no state. A level-enabled output drops one cycle after its input line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte address inside the per-processor window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| level_in | input | 32 | Polarity-adjusted input vector from the bank |
| edge_pulse | input | 32 | One-cycle edge event pulses from the bank |
| irq | output | 16 | Grouped interrupts, four per processor, processor-major |

## Verification
A corrupted cause or mask bit shows up on that processor's grouped output one cycle after the stimulus, and on a readback in the cycle after the read strobe. Cross-talk between processors shows as a changed cause or mask on a processor that was not written, so every line is swept through the edge and level paths while all four cause registers are read back after each clear. A stuck level path shows as an output that stays high one cycle after its line drops.

// File: rtl/gpio_pcpu_pkg.sv
package gpio_pcpu_pkg;
  // register kind, taken from the address bits above the processor number
  typedef enum logic [1:0] {
    KIND_CAUSE = 2'd0,
    KIND_EMASK = 2'd1,
    KIND_LMASK = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpio_pcpu_slice.sv
// One processor's cause latch, masks and grouped interrupt outputs.
module gpio_pcpu_slice #(
  parameter int NLINE = 32,
  parameter int GRP   = 8,
  localparam int NGRP = NLINE / GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cause,
  input  logic             wr_emask,
  input  logic             wr_lmask,
  input  logic [NLINE-1:0] wdata,
  input  logic [NLINE-1:0] edge_pulse,
  input  logic [NLINE-1:0] level_in,
  output logic [NLINE-1:0] cause_q,
  output logic [NLINE-1:0] emask_q,
  output logic [NLINE-1:0] lmask_q,
  output logic [NGRP-1:0]  irq_q
);
  logic [NLINE-1:0] keep;
  logic [NLINE-1:0] pend;

  // a cause write clears zero bits; a new pulse wins over a clear
  assign keep = wr_cause ? wdata : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      cause_q <= (cause_q & keep) | edge_pulse;
      if (wr_emask) emask_q <= wdata;
      if (wr_lmask) lmask_q <= wdata;
    end
  end

  assign pend = (level_in & lmask_q) | (cause_q & emask_q);

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (rst) irq_q[g] <= 1'b0;
        else     irq_q[g] <= |pend[g*GRP +: GRP];
      end
    end
  endgenerate

  // R3
  edge_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|edge_pulse) |=> ((cause_q & $past(edge_pulse)) == $past(edge_pulse)));

  // R4
  cause_rise_only_by_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(edge_pulse)) == '0));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (emask_q == '0 && lmask_q == '0) |=> (irq_q == '0));

endmodule

// File: rtl/gpio_pcpu_rdmux.sv
// Registered read-back multiplexer for the per-processor window.
module gpio_pcpu_rdmux
  import gpio_pcpu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NLINE = 32,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  reg_kind_e                  kind,
  input  logic [CPUW-1:0]            cpu,
  input  logic [NCPU-1:0][NLINE-1:0] cause,
  input  logic [NCPU-1:0][NLINE-1:0] emask,
  input  logic [NCPU-1:0][NLINE-1:0] lmask,
  output logic [NLINE-1:0]           rdata
);
  logic [NLINE-1:0] sel;

  always_comb begin
    unique case (kind)
      KIND_CAUSE: sel = cause[cpu];
      KIND_EMASK: sel = emask[cpu];
      KIND_LMASK: sel = lmask[cpu];
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && kind == KIND_NONE) |=> (rdata == '0));

endmodule

// File: rtl/gpio_pcpu_irq_router.sv
// Per-processor GPIO interrupt routing: window decode, slices, read-back.
module gpio_pcpu_irq_router
  import gpio_pcpu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NLINE = 32,
  parameter int GRP   = 8,
  localparam int NGRP = NLINE / GRP,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int AW   = CPUW + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wr,
  input  logic [NLINE-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [NLINE-1:0]     reg_rdata,
  input  logic [NLINE-1:0]     level_in,
  input  logic [NLINE-1:0]     edge_pulse,
  output logic [NCPU*NGRP-1:0] irq
);
  reg_kind_e       kind;
  logic [CPUW-1:0] cpu;

  // byte stride of four per processor, one 4*NCPU-byte block per kind
  assign kind = reg_kind_e'(reg_addr[AW-1 -: 2]);
  assign cpu  = reg_addr[2 +: CPUW];

  logic [NCPU-1:0][NLINE-1:0] cause_all;
  logic [NCPU-1:0][NLINE-1:0] emask_all;
  logic [NCPU-1:0][NLINE-1:0] lmask_all;

  genvar c;
  generate
    for (c = 0; c < NCPU; c++) begin : g_cpu
      logic hit;
      assign hit = reg_wr && (cpu == CPUW'(c));

      gpio_pcpu_slice #(.NLINE(NLINE), .GRP(GRP)) u_slice (
        .clk        (clk),
        .rst        (rst),
        .wr_cause   (hit && kind == KIND_CAUSE),
        .wr_emask   (hit && kind == KIND_EMASK),
        .wr_lmask   (hit && kind == KIND_LMASK),
        .wdata      (reg_wdata),
        .edge_pulse (edge_pulse),
        .level_in   (level_in),
        .cause_q    (cause_all[c]),
        .emask_q    (emask_all[c]),
        .lmask_q    (lmask_all[c]),
        .irq_q      (irq[c*NGRP +: NGRP])
      );
    end
  endgenerate

  gpio_pcpu_rdmux #(.NCPU(NCPU), .NLINE(NLINE)) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .kind  (kind),
    .cpu   (cpu),
    .cause (cause_all),
    .emask (emask_all),
    .lmask (lmask_all),
    .rdata (reg_rdata)
  );

  // R1
  reset_clears_irq_chk: assert property (@(posedge clk)
    rst |=> (irq == '0 && reg_rdata == '0));

  // R7
  masks_hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(emask_all) && $stable(lmask_all)));

endmodule

// File: tb/gpio_pcpu_irq_router_bench.sv
module gpio_pcpu_irq_router_bench;
  localparam int NCPU = 4;
  localparam int NL   = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] level_in = '0;
  logic [31:0] edge_pulse = '0;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cause [NCPU];
  logic [31:0] m_em    [NCPU];
  logic [31:0] m_lm    [NCPU];

  always #5 clk = ~clk;

  gpio_pcpu_irq_router u_gpio_pcpu_irq_router (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .level_in(level_in), .edge_pulse(edge_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_irq();
    logic [15:0] r;
    for (int c = 0; c < NCPU; c++) begin
      logic [31:0] p;
      p = (level_in & m_lm[c]) | (m_cause[c] & m_em[c]);
      for (int g = 0; g < 4; g++) r[c*4+g] = |p[g*8 +: 8];
    end
    return r;
  endfunction

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic check_irq(input string req);
    idle();
    check(req, {16'h0, irq}, {16'h0, exp_irq()});
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] d;
    for (int c = 0; c < NCPU; c++) begin
      rd(6'(c*4), d);        check({req, " cause"}, d, m_cause[c]);
      rd(6'(16 + c*4), d);   check({req, " emask"}, d, m_em[c]);
      rd(6'(32 + c*4), d);   check({req, " lmask"}, d, m_lm[c]);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_em[c] = '0; m_lm[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {16'h0, irq}, 32'h0);
    check_all_regs("R1");

    // R2 mask map, distinct values per processor
    for (int c = 0; c < NCPU; c++) begin
      m_em[c] = 32'h0101_0101 << c;
      m_lm[c] = 32'h8040_2010 >> c;
      wr(6'(16 + c*4), m_em[c]);
      wr(6'(32 + c*4), m_lm[c]);
    end
    check_all_regs("R2");
    check_irq("R6 idle");

    // R8 unmapped window
    for (int c = 0; c < NCPU; c++) begin
      wr(6'(48 + c*4), 32'hFFFF_FFFF);
      rd(6'(48 + c*4), d);
      check("R8 unmapped read", d, 32'h0);
    end
    check_all_regs("R8");
    check_irq("R8 irq");

    // R6 / R9 level sweep
    for (int i = 0; i < NL; i++) begin
      level_in = 32'h1 << i;
      check_irq("R6 level");
    end
    level_in = '0;
    check_irq("R9 level drop");
    level_in = 32'hFFFF_FFFF;
    check_irq("R6 level all");
    level_in = '0;
    idle();
    check("R9 drop after one cycle", {16'h0, irq}, 32'h0);

    // all edge masks open so every cause bit reaches the outputs
    for (int c = 0; c < NCPU; c++) begin
      m_em[c] = 32'hFFFF_FFFF;
      wr(6'(16 + c*4), m_em[c]);
    end

    // R3 / R4 / R7 edge sweep
    for (int i = 0; i < NL; i++) begin
      int own;
      own = i % NCPU;
      edge_pulse = 32'h1 << i;
      idle();
      edge_pulse = '0;
      for (int c = 0; c < NCPU; c++) m_cause[c] |= 32'h1 << i;
      check_irq("R6 edge");
      for (int c = 0; c < NCPU; c++) begin
        rd(6'(c*4), d);
        check("R3 cause set everywhere", d, m_cause[c]);
      end
      wr(6'(own*4), ~(32'h1 << i));
      m_cause[own] &= ~(32'h1 << i);
      for (int c = 0; c < NCPU; c++) begin
        rd(6'(c*4), d);
        check("R4 R7 clear own only", d, m_cause[c]);
      end
      check_irq("R7 irq isolation");
    end

    // R4 writing ones leaves bits alone
    wr(6'd4, 32'hFFFF_FFFF);
    rd(6'd4, d);
    check("R4 ones keep", d, m_cause[1]);

    // R5 pulse and clear in the same cycle
    reg_addr = 6'd0; reg_wdata = 32'h0; reg_wr = 1'b1;
    edge_pulse = 32'h0000_0008;
    idle();
    reg_wr = 1'b0; edge_pulse = '0;
    m_cause[0] = 32'h0000_0008;
    for (int c = 1; c < NCPU; c++) m_cause[c] |= 32'h0000_0008;
    rd(6'd0, d);
    check("R5 pulse wins", d, 32'h0000_0008);
    check_irq("R5 irq");

    // R7 masking one processor leaves others
    m_em[2] = '0; m_lm[2] = '0;
    wr(6'd24, 32'h0);
    wr(6'd40, 32'h0);
    level_in = 32'h00FF_00FF;
    check_irq("R7 masked processor");
    check("R7 cpu2 quiet", {28'h0, irq[11:8]}, 32'h0);
    check_all_regs("R7");

    // R1 reset again clears everything
    rst = 1'b1;
    idle();
    rst = 1'b0;
    level_in = '0;
    for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_em[c] = '0; m_lm[c] = '0; end
    check("R1 irq after reset", {16'h0, irq}, 32'h0);
    check_all_regs("R1 again");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule